// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block holds the architectural registers of a small processor: eight 32-bit words, read through two combinational ports and written through two ports that commit together on the rising clock edge. One write port carries the result of the arithmetic unit and the other carries a value loaded from memory. Both write ports can update different registers in the same cycle, for example a stack-pointer adjustment and a loaded value landing together.

Each port is addressed by a 4-bit register number. Numbers 0 to 7 select a register, and register 4 serves as the stack pointer. Any number from 8 upward means "no access": such a write changes nothing and such a read returns zero. When both write ports name the same register in one cycle, the memory-side port wins. A pop into the stack pointer therefore leaves the popped value there, not the adjusted pointer. A synchronous reset clears every register.

Top module: `dual_wport_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero; reads after that edge return zero for IDs 0 to 7.
- R2: `rdDataA` shows the current content of the register selected by `rdIdA`, combinationally, with no clock edge in between.
- R3: `rdDataB` shows the current content of the register selected by `rdIdB`, combinationally and independent of port A.
- R4: With `wrIdE` in 0..7 and no M-port write to the same register, `wrDataE` is stored in that register at the rising edge.
- R5: With `wrIdM` in 0..7, `wrDataM` is stored in that register at the rising edge.
- R6: When E and M name two different valid registers in one cycle, both registers take their new values at the same edge.
- R7: When E and M name the same register in one cycle, the register holds `wrDataM` after the edge; for ID 4 (stack pointer), the value written through M remains.
- R8: A write ID from 8 to 15 on either port changes no register.
- R9: A read ID from 8 to 15 on either read port returns 32'h0.
- R10: A read in the cycle of a write to the same register returns the old value; the new value appears only after the rising edge.
- R11: Reset takes priority: a write presented in the same cycle as reset is dropped, and the register reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rdIdA | input | 4 | Register number for read port A (8..15: no access) |
| rdIdB | input | 4 | Register number for read port B (8..15: no access) |
| rdDataA | output | 32 | Content of the register selected by `rdIdA` |
| rdDataB | output | 32 | Content of the register selected by `rdIdB` |
| wrIdE | input | 4 | Register number for write port E (8..15: no write) |
| wrDataE | input | 32 | Data for write port E |
| wrIdM | input | 4 | Register number for write port M (8..15: no write); wins on collision |
| wrDataM | input | 32 | Data for write port M |

## Verification
The read data responds in zero cycles: the bench applies a read ID, waits one time unit for the combinational path and compares there. A write is due one edge after it is presented. Write IDs and data are driven on a falling edge, the rising edge commits them, and the write IDs return to "no access" just after that edge, so each write task commits exactly one cycle's worth of data. The same-cycle visibility and reset-priority cases are checked on both sides of the committing edge: the old value before the edge, and the new value or zero after it.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Per-register strobe bundle passed from write control to the storage.
  typedef struct packed {
    logic load;   // register updates at the next edge
    logic takeM;  // source is the M port (else the E port)
  } regStrobe_t;

endpackage

// File: rtl/rf_write_ctrl.sv
module rf_write_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ID_W     = 4
) (
  input  logic       rst,
  input  logic [ID_W-1:0] wrIdE,
  input  logic [ID_W-1:0] wrIdM,
  output logic       clearAll,
  output regStrobe_t strobes [NUM_REGS]
);

  assign clearAll = rst;

  // IDs at or above NUM_REGS match no slot, so they produce no write.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    logic hitE;
    logic hitM;
    assign hitE = (wrIdE == ID_W'(r));
    assign hitM = (wrIdM == ID_W'(r));
    // M port has priority on a same-register collision.
    assign strobes[r].load  = hitE | hitM;
    assign strobes[r].takeM = hitM;
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int ID_W     = 4
) (
  input  logic              clk,
  input  logic              clearAll,
  input  regStrobe_t        strobes [NUM_REGS],
  input  logic [DATA_W-1:0] wrDataE,
  input  logic [DATA_W-1:0] wrDataM,
  input  logic [ID_W-1:0]   rdIdA,
  input  logic [ID_W-1:0]   rdIdB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (clearAll) begin
        regQ[r] <= '0;
      end else if (strobes[r].load) begin
        regQ[r] <= strobes[r].takeM ? wrDataM : wrDataE;
      end
    end
  end

  // Read muxes: out-of-range IDs yield zero.
  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rdIdA == ID_W'(r)) rdDataA = regQ[r];
      if (rdIdB == ID_W'(r)) rdDataB = regQ[r];
    end
  end

endmodule

// File: rtl/dual_wport_regfile.sv
module dual_wport_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int ID_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rdIdA,
  input  logic [ID_W-1:0]   rdIdB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ID_W-1:0]   wrIdE,
  input  logic [DATA_W-1:0] wrDataE,
  input  logic [ID_W-1:0]   wrIdM,
  input  logic [DATA_W-1:0] wrDataM
);

  logic       clearAll;
  regStrobe_t strobes [NUM_REGS];

  rf_write_ctrl #(
    .NUM_REGS(NUM_REGS),
    .ID_W    (ID_W)
  ) u_ctrl (
    .rst     (rst),
    .wrIdE   (wrIdE),
    .wrIdM   (wrIdM),
    .clearAll(clearAll),
    .strobes (strobes)
  );

  rf_storage #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .ID_W    (ID_W)
  ) u_store (
    .clk     (clk),
    .clearAll(clearAll),
    .strobes (strobes),
    .wrDataE (wrDataE),
    .wrDataM (wrDataM),
    .rdIdA   (rdIdA),
    .rdIdB   (rdIdB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int ID_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   rdIdA,
  input logic [ID_W-1:0]   rdIdB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic [ID_W-1:0]   wrIdE,
  input logic [DATA_W-1:0] wrDataE,
  input logic [ID_W-1:0]   wrIdM,
  input logic [DATA_W-1:0] wrDataM
);

  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_REGS);

  logic validE, validM, validA, validB;
  assign validE = {1'b0, wrIdE} < LIMIT;
  assign validM = {1'b0, wrIdM} < LIMIT;
  assign validA = {1'b0, rdIdA} < LIMIT;
  assign validB = {1'b0, rdIdB} < LIMIT;

  // R1: a reset edge leaves every register at zero.
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rdDataA == '0 && rdDataB == '0));

  // R4: an uncontested E write is visible after the edge.
  a_r4_e_write: assert property (@(posedge clk) disable iff (rst)
    (validE && wrIdE != wrIdM) |=>
      (rdIdA != $past(wrIdE) || rdDataA == $past(wrDataE)));

  // R5 / R7: an M write is visible after the edge, whatever E does.
  a_r7_m_wins: assert property (@(posedge clk) disable iff (rst)
    validM |=> (rdIdB != $past(wrIdM) || rdDataB == $past(wrDataM)));

  // R8: with no valid write, a held read ID keeps its data.
  a_r8_null_write: assert property (@(posedge clk) disable iff (rst)
    (!validE && !validM) |=>
      (rdIdA != $past(rdIdA) || rdDataA == $past(rdDataA)));

  // R9: out-of-range read IDs return zero.
  a_r9_null_read: assert property (@(posedge clk) disable iff (rst)
    (!validA |-> rdDataA == '0) and (!validB |-> rdDataB == '0));

endmodule

bind dual_wport_regfile rf_checker #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .ID_W    (ID_W)
) u_rf_checker (
  .clk    (clk),
  .rst    (rst),
  .rdIdA  (rdIdA),
  .rdIdB  (rdIdB),
  .rdDataA(rdDataA),
  .rdDataB(rdDataB),
  .wrIdE  (wrIdE),
  .wrDataE(wrDataE),
  .wrIdM  (wrIdM),
  .wrDataM(wrDataM)
);

// File: tb/test_dual_wport_regfile.sv
module test_dual_wport_regfile;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NOREG = 4'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rdIdA = NOREG, rdIdB = NOREG, wrIdE = NOREG, wrIdM = NOREG;
  logic [31:0] wrDataE = '0, wrDataM = '0;
  logic [31:0] rdDataA, rdDataB;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wport_regfile i_dual_wport_regfile (
    .clk(clk), .rst(rst),
    .rdIdA(rdIdA), .rdIdB(rdIdB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrIdE(wrIdE), .wrDataE(wrDataE), .wrIdM(wrIdM), .wrDataM(wrDataM)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one write cycle, commit it, then return both ports to no access.
  task automatic doWrite(logic [3:0] eId, logic [31:0] eVal,
                         logic [3:0] mId, logic [31:0] mVal);
    @(negedge clk);
    wrIdE = eId; wrDataE = eVal; wrIdM = mId; wrDataM = mVal;
    @(posedge clk);
    #1;
    wrIdE = NOREG; wrIdM = NOREG;
  endtask

  task automatic readA(logic [3:0] id, logic [31:0] exp, string req);
    rdIdA = id; #1; check(req, rdDataA, exp);
  endtask

  task automatic readB(logic [3:0] id, logic [31:0] exp, string req);
    rdIdB = id; #1; check(req, rdDataB, exp);
  endtask

  function automatic logic [31:0] patt(int r);
    return 32'hC0DE_0000 + 32'(r * 32'h0101);
  endfunction

  task automatic fillAll();
    for (int r = 0; r < 8; r++) doWrite(4'(r), patt(r), NOREG, '0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 8; r++) readA(4'(r), '0, "R1 reset state");
  endtask

  task automatic t_single_e();
    doWrite(4'd3, 32'h1234_5678, NOREG, '0);
    readA(4'd3, 32'h1234_5678, "R4 E write / R2 read A");
    readB(4'd3, 32'h1234_5678, "R3 read B");
  endtask

  task automatic t_single_m();
    doWrite(NOREG, '0, 4'd5, 32'hDEAD_BEEF);
    readB(4'd5, 32'hDEAD_BEEF, "R5 M write / R3 read B");
    readA(4'd3, 32'h1234_5678, "R2 read A independent");
  endtask

  task automatic t_dual();
    doWrite(4'd1, 32'h1111_0001, 4'd2, 32'h2222_0002);
    readA(4'd1, 32'h1111_0001, "R6 dual write E side");
    readB(4'd2, 32'h2222_0002, "R6 dual write M side");
  endtask

  task automatic t_collision();
    doWrite(4'd4, 32'h0000_0FFC, 4'd4, 32'hAAAA_5555);
    readA(4'd4, 32'hAAAA_5555, "R7 collision on stack pointer");
    doWrite(4'd0, 32'h0BAD_0BAD, 4'd0, 32'h600D_600D);
    readB(4'd0, 32'h600D_600D, "R7 collision on reg 0");
  endtask

  task automatic t_null_write();
    fillAll();
    doWrite(4'd8, 32'hFFFF_FFFF, 4'd9, 32'hEEEE_EEEE);
    doWrite(4'd15, 32'h1357_9BDF, 4'd12, 32'h2468_ACE0);
    for (int r = 0; r < 8; r++) readA(4'(r), patt(r), "R8 null write");
  endtask

  task automatic t_null_read();
    readA(4'd8, '0, "R9 null read A id 8");
    readB(4'd15, '0, "R9 null read B id 15");
    readA(4'd11, '0, "R9 null read A id 11");
  endtask

  task automatic t_visibility();
    @(negedge clk);
    rdIdA = 4'd6; wrIdE = 4'd6; wrDataE = 32'h7777_0006;
    #1; check("R10 old value before edge", rdDataA, patt(6));
    @(posedge clk);
    #1; wrIdE = NOREG;
    check("R10 new value after edge", rdDataA, 32'h7777_0006);
  endtask

  task automatic t_reset_priority();
    @(negedge clk);
    rst = 1'b1; wrIdE = 4'd2; wrDataE = 32'h9999_9999;
    wrIdM = 4'd7; wrDataM = 32'h8888_8888;
    @(posedge clk);
    #1; rst = 1'b0; wrIdE = NOREG; wrIdM = NOREG;
    readA(4'd2, '0, "R11 reset beats E write");
    readB(4'd7, '0, "R11 reset beats M write");
    for (int r = 0; r < 8; r++) readA(4'(r), '0, "R1 reset clears loaded file");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_single_e();
    t_single_m();
    t_dual();
    t_collision();
    t_null_write();
    t_null_read();
    t_visibility();
    t_reset_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule